// File: doc/BRIEF.md
# Match Position Buffer and Start-Address Encoder

This block sits behind a multi-lane signature matcher. While a packet streams past, the matcher reports a signature-end hit per lane and per signature on every cycle. The block records each hit as one flag in a position buffer, indexed by the byte position where the signature ended. A byte counter advances by the lane count on each streaming cycle, and the lane number supplies the low part of the byte position.

When the packet has gone past, the controller raises the report enable. A binary tree of two-input nodes then picks the pending flag with the lowest index, so the earliest end position is chosen first, and a lower signature number wins when two signatures end on the same byte. Each tree node passes up a "something pending" flag and one more bit of the winning index. The same tree drives a one-hot grant back down, and that grant clears the chosen flag.

For each chosen flag the block computes the start address of the matched signature as end position minus signature length plus one, using a length table held in a parameter. It emits one address per cycle. Once the buffer is empty it raises a finish flag, so a packet with M matches needs M+1 report cycles.

Top module: `match_addr_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `addr_valid` and `finish` become 0, the buffer empties and the byte counter returns to 0. After reset, one report cycle on the empty buffer yields `finish`=1 and `addr_valid`=0.
- R2: A capture cycle is a cycle with `stream_valid`=1 and `report_en`=0. In a capture cycle, bit `lane*NSIG+sig` of `match_in` records an end of signature `sig` at byte position `count+lane`. The counter starts at 0 and grows by `LANES` in each capture cycle.
- R3: Matches presented while `stream_valid`=0 or `report_en`=1 are not recorded, and in those cycles the counter does not move.
- R4: The counter stops at `MAX_BYTES`. Hits whose byte position is `MAX_BYTES` or more are dropped.
- R5: Pending matches are reported in order of increasing end position. At equal end position, the lower signature number is reported first.
- R6: The reported address is `(end - SIG_LEN[sig] + 1) mod 2^AW`, where `SIG_LEN[sig]` is byte field `sig` of the length parameter (signature 0 in the low byte). It appears on `start_addr` with `addr_valid`=1 in the cycle after the report cycle that selected it.
- R7: Each reported match is cleared from the buffer. With M pending matches and `report_en` held high, `addr_valid` is 1 on M consecutive cycles, followed by `finish`=1 with `addr_valid`=0.
- R8: `finish` stays 1 while `report_en` stays high. Both outputs are 0 in the cycle after a cycle with `report_en`=0. Reporting that is paused resumes with the matches still pending.
- R9: `sm_clr` empties the buffer, zeroes the counter and clears both outputs, and it takes priority over capture and reporting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sm_clr | input | 1 | Synchronous buffer and counter clear |
| stream_valid | input | 1 | Packet data is streaming this cycle |
| match_in | input | NSIG*LANES | Per-lane, per-signature end hits, bit lane*NSIG+sig |
| report_en | input | 1 | Report pending matches, one per cycle |
| start_addr | output | AW | Start byte address of the reported match |
| addr_valid | output | 1 | start_addr holds a reported match |
| finish | output | 1 | Buffer found empty while reporting |

## Verification
The bench goes after the ordering corner cases. It places two signatures ending on the same byte, and a design that ordered by signature first or dropped the tie would show the wrong second address. Short signatures ending near byte 0 test the modular start address, and a design with the wrong width would print large or negative values. Hits after the counter saturates, or during idle and report cycles, must leave no extra address before `finish`. A drain that is paused, and one cut off by a clear, checks that grants clear exactly one flag each. A design that cleared too much would finish early, and one that cleared nothing would repeat the same address.

// File: rtl/mpenc_pkg.sv
// Shared constants and helpers for the match position encoder.
// Assumes signature count and lane count are powers of two.
package mpenc_pkg;
    // Width of one entry of the signature length table.
    localparam int LEN_W = 8;

    // Bit of the per-cycle hit vector belonging to a lane and signature.
    function automatic int hit_bit(input int lane, input int sig, input int nsig);
        return lane * nsig + sig;
    endfunction
endpackage

// File: rtl/mpenc_capture.sv
// Position buffer and byte counter.
// Records hits as flags indexed pos*NSIG+sig, clears flags granted by the
// encoder tree. Assumes MAX_BYTES is a multiple of LANES.
module mpenc_capture #(
    parameter int LANES     = 4,
    parameter int NSIG      = 2,
    parameter int MAX_BYTES = 32,
    localparam int NPOS     = MAX_BYTES * NSIG,
    localparam int CW       = $clog2(MAX_BYTES + LANES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sm_clr,
    input  logic                  stream_valid,
    input  logic                  report_en,
    input  logic [NSIG*LANES-1:0] match_in,
    input  logic [NPOS-1:0]       grant,
    output logic [NPOS-1:0]       flags
);
    logic [CW-1:0]   count_q;
    logic [NPOS-1:0] set_vec;
    logic            cap_en;

    assign cap_en = stream_valid && !report_en && (int'(count_q) < MAX_BYTES);

    // Map this cycle's lane hits onto buffer flag positions.
    always_comb begin
        set_vec = '0;
        if (cap_en) begin
            for (int l = 0; l < LANES; l++) begin
                for (int s = 0; s < NSIG; s++) begin
                    if (match_in[mpenc_pkg::hit_bit(l, s, NSIG)]) begin
                        set_vec[(int'(count_q) + l) * NSIG + s] = 1'b1;
                    end
                end
            end
        end
    end

    // Byte counter: advances by the lane count per capture cycle, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n || sm_clr) begin
            count_q <= '0;
        end else if (cap_en) begin
            count_q <= count_q + CW'(LANES);
        end
    end

    // Flag buffer: set on hits, cleared by the tree grant while reporting.
    always_ff @(posedge clk) begin
        if (!rst_n || sm_clr) begin
            flags <= '0;
        end else if (report_en) begin
            flags <= flags & ~grant;
        end else begin
            flags <= flags | set_vec;
        end
    end
endmodule

// File: rtl/mpenc_tree.sv
// Binary tree priority encoder over the flag buffer.
// Heap-numbered nodes: root 1, children 2n and 2n+1, leaves NPOS..2NPOS-1.
// Each node forwards a pending flag and one more index bit; a top-down
// enable path produces a one-hot grant for the lowest pending flag.
// Assumes NPOS is a power of two.
module mpenc_tree #(
    parameter int NPOS = 64,
    localparam int LV  = $clog2(NPOS),
    localparam int IW  = LV
) (
    input  logic [NPOS-1:0] flags,
    output logic            any,
    output logic [IW-1:0]   idx,
    output logic [NPOS-1:0] grant
);
    logic          any_h [1:2*NPOS-1];
    logic [IW-1:0] idx_h [1:2*NPOS-1];
    logic          en_h  [1:2*NPOS-1];

    assign en_h[1] = 1'b1;
    assign any     = any_h[1];
    assign idx     = idx_h[1];

    // Leaves: one per flag, grant when the path reaches a set flag.
    for (genvar i = 0; i < NPOS; i++) begin : g_leaf
        assign any_h[NPOS+i] = flags[i];
        assign idx_h[NPOS+i] = '0;
        assign grant[i]      = en_h[NPOS+i] & flags[i];
    end

    // Internal nodes: left child wins whenever it has anything pending.
    for (genvar d = 0; d < LV; d++) begin : g_lvl
        for (genvar k = 0; k < (1 << d); k++) begin : g_node
            localparam int N = (1 << d) + k;
            assign any_h[N]     = any_h[2*N] | any_h[2*N+1];
            assign idx_h[N]     = any_h[2*N] ? idx_h[2*N]
                                             : (idx_h[2*N+1] | (IW'(1) << (LV - 1 - d)));
            assign en_h[2*N]    = en_h[N] & any_h[2*N];
            assign en_h[2*N+1]  = en_h[N] & ~any_h[2*N];
        end
    end
endmodule

// File: rtl/mpenc_report.sv
// Output stage: turns the winning index into a start address and registers
// address, valid and finish. Assumes NSIG is a power of two of at least 2.
module mpenc_report #(
    parameter int NSIG      = 2,
    parameter int MAX_BYTES = 32,
    parameter logic [NSIG*mpenc_pkg::LEN_W-1:0] SIG_LEN = '0,
    localparam int AW       = $clog2(MAX_BYTES),
    localparam int SW       = $clog2(NSIG),
    localparam int IW       = AW + SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sm_clr,
    input  logic          report_en,
    input  logic          any,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] start_addr,
    output logic          addr_valid,
    output logic          finish
);
    logic [SW-1:0]               sig;
    logic [AW-1:0]               end_pos;
    logic [mpenc_pkg::LEN_W-1:0] len;
    logic [AW-1:0]               start_nx;

    // Split the index into end position and signature, then back off.
    always_comb begin
        sig      = idx[SW-1:0];
        end_pos  = idx[IW-1:SW];
        len      = SIG_LEN[int'(sig)*mpenc_pkg::LEN_W +: mpenc_pkg::LEN_W];
        start_nx = end_pos - AW'(len) + AW'(1);
    end

    // Register one report result per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || sm_clr) begin
            start_addr <= '0;
            addr_valid <= 1'b0;
            finish     <= 1'b0;
        end else if (report_en) begin
            addr_valid <= any;
            finish     <= !any;
            if (any) begin
                start_addr <= start_nx;
            end
        end else begin
            addr_valid <= 1'b0;
            finish     <= 1'b0;
        end
    end
endmodule

// File: rtl/match_addr_encoder.sv
// Top: match position buffer with tree encoder and start-address output.
// Captures lane hits while streaming, then drains one match per report
// cycle, lowest end position first, and flags finish on an empty buffer.
module match_addr_encoder #(
    parameter int LANES     = 4,
    parameter int NSIG      = 2,
    parameter int MAX_BYTES = 32,
    parameter logic [NSIG*mpenc_pkg::LEN_W-1:0] SIG_LEN = {8'd5, 8'd3},
    localparam int AW       = $clog2(MAX_BYTES),
    localparam int NPOS     = MAX_BYTES * NSIG,
    localparam int IW       = $clog2(NPOS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sm_clr,
    input  logic                  stream_valid,
    input  logic [NSIG*LANES-1:0] match_in,
    input  logic                  report_en,
    output logic [AW-1:0]         start_addr,
    output logic                  addr_valid,
    output logic                  finish
);
    logic [NPOS-1:0] flags;
    logic [NPOS-1:0] grant;
    logic            any;
    logic [IW-1:0]   idx;

    mpenc_capture #(.LANES(LANES), .NSIG(NSIG), .MAX_BYTES(MAX_BYTES)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .sm_clr       (sm_clr),
        .stream_valid (stream_valid),
        .report_en    (report_en),
        .match_in     (match_in),
        .grant        (grant),
        .flags        (flags)
    );

    mpenc_tree #(.NPOS(NPOS)) u_tree (
        .flags (flags),
        .any   (any),
        .idx   (idx),
        .grant (grant)
    );

    mpenc_report #(.NSIG(NSIG), .MAX_BYTES(MAX_BYTES), .SIG_LEN(SIG_LEN)) u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .sm_clr     (sm_clr),
        .report_en  (report_en),
        .any        (any),
        .idx        (idx),
        .start_addr (start_addr),
        .addr_valid (addr_valid),
        .finish     (finish)
    );
endmodule

// File: rtl/match_addr_encoder_chk.sv
// Protocol checker for the match address encoder, bound to the top.
module match_addr_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic sm_clr,
    input logic report_en,
    input logic addr_valid,
    input logic finish
);
    // R8
    out_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid || finish) |-> $past(report_en));

    // R9
    clr_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sm_clr |=> (!addr_valid && !finish));

    // R9
    clr_then_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sm_clr) && report_en && !sm_clr) |=> finish);

    // R8
    finish_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && report_en && !sm_clr) |=> finish);

    // R7
    drain_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && report_en && !sm_clr) |=> (addr_valid || finish));
endmodule

bind match_addr_encoder match_addr_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sm_clr     (sm_clr),
    .report_en  (report_en),
    .addr_valid (addr_valid),
    .finish     (finish)
);

// File: tb/match_addr_encoder_bench.sv
// Directed bench: one task per scenario, defaults LANES=4, NSIG=2,
// MAX_BYTES=32, signature lengths 3 (sig0) and 5 (sig1).
module match_addr_encoder_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sm_clr = 1'b0;
    logic       stream_valid = 1'b0;
    logic [7:0] match_in = '0;
    logic       report_en = 1'b0;
    logic [4:0] start_addr;
    logic       addr_valid;
    logic       finish;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    match_addr_encoder u_match_addr_encoder (
        .clk(clk), .rst_n(rst_n), .sm_clr(sm_clr), .stream_valid(stream_valid),
        .match_in(match_in), .report_en(report_en),
        .start_addr(start_addr), .addr_valid(addr_valid), .finish(finish)
    );

    // Apply inputs for one cycle; returns at the following falling edge.
    task automatic drive(input bit sv, input logic [7:0] mv, input bit ren, input bit clr);
        stream_valid = sv; match_in = mv; report_en = ren; sm_clr = clr;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input bit v, input bit f, input int a, input string req);
        chk(addr_valid == v, {req, " valid"}, int'(addr_valid), int'(v));
        chk(finish == f, {req, " finish"}, int'(finish), int'(f));
        if (v) chk(int'(start_addr) == a, {req, " addr"}, int'(start_addr), a);
    endtask

    // Drain n expected addresses, then expect finish, hold, and idle.
    task automatic drain(input int n, input int exp [0:3], input bit inject, input string req);
        for (int i = 0; i < n; i++) begin
            drive(inject, inject ? 8'hFF : 8'h00, 1'b1, 1'b0);
            chk_out(1'b1, 1'b0, exp[i], req);
        end
        drive(inject, inject ? 8'hFF : 8'h00, 1'b1, 1'b0);
        chk_out(1'b0, 1'b1, 0, {req, " R7 finish"});
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        chk_out(1'b0, 1'b1, 0, "R8 finish held");
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        chk_out(1'b0, 1'b0, 0, "R8 idle after report");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b1, 8'hFF, 1'b1, 1'b0);
        drive(1'b1, 8'hFF, 1'b1, 1'b0);
        chk_out(1'b0, 1'b0, 0, "R1 in reset");
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        chk_out(1'b0, 1'b1, 0, "R1 empty after reset");
        drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    // R2 R5 R6: capture across lanes, tie at byte 12 ordered by signature.
    task automatic t_basic();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        chk_out(1'b0, 1'b0, 0, "R9 after clear");
        drive(1'b1, 8'h40, 1'b0, 1'b0);  // sig0 lane3 -> end 3
        drive(1'b1, 8'h20, 1'b0, 1'b0);  // sig1 lane2 -> end 6
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        drive(1'b1, 8'h03, 1'b0, 1'b0);  // both sigs lane0 -> end 12
        drain(4, '{1, 2, 10, 8}, 1'b0, "R2 R5 R6 basic");
    endtask

    // R3: idle and report-time hits ignored, counter holds.
    task automatic t_ignore();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        drive(1'b0, 8'hFF, 1'b0, 1'b0);
        drive(1'b1, 8'h04, 1'b0, 1'b0);  // sig0 lane1 -> end 5
        drain(1, '{3, 0, 0, 0}, 1'b1, "R3 ignored hits");
    endtask

    // R4: counter saturates, late hits dropped.
    task automatic t_capacity();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 7; i++) drive(1'b1, 8'h00, 1'b0, 1'b0);
        drive(1'b1, 8'h80, 1'b0, 1'b0);  // sig1 lane3 -> end 31
        drive(1'b1, 8'hFF, 1'b0, 1'b0);
        drive(1'b1, 8'hFF, 1'b0, 1'b0);
        drain(1, '{27, 0, 0, 0}, 1'b0, "R4 capacity");
    endtask

    // R6 R8: wrapped start addresses, paused drain resumes.
    task automatic t_pause();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        drive(1'b1, 8'h15, 1'b0, 1'b0);  // sig0 lanes 0,1,2 -> ends 0,1,2
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        chk_out(1'b1, 1'b0, 30, "R6 wrapped start");
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        chk_out(1'b0, 1'b0, 0, "R8 paused");
        drain(2, '{31, 0, 0, 0}, 1'b0, "R8 resume");
    endtask

    // R9: clear in the middle of a drain empties the buffer.
    task automatic t_clear();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        drive(1'b1, 8'h03, 1'b0, 1'b0);  // end 0: sig0 start 30, sig1 start 28
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        chk_out(1'b1, 1'b0, 30, "R9 before clear");
        drive(1'b0, 8'h00, 1'b1, 1'b1);
        chk_out(1'b0, 1'b0, 0, "R9 clear wins");
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        chk_out(1'b0, 1'b1, 0, "R9 empty after clear");
        drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    bit done = 1'b0;

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_ignore();
        t_capacity();
        t_pause();
        t_clear();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule